// File: doc/BRIEF.md
# Bit Test-and-Clear Execution Unit

This datapath unit performs one step of a single-bit test-and-clear instruction on operands that are already fetched. It receives the destination value, two possible bit-number sources and a condition-code vector. It returns the destination with the addressed bit forced low. It also returns the condition codes, in which only the zero flag is rewritten. That flag reports the state of the bit before it was cleared.

The width of the operation depends on where the destination lives. A data-register destination is 32 bits wide, and its bit number wraps modulo 32. A memory destination is a single byte, so its bit number wraps modulo 8 and the upper 24 bits of the operand pass straight through. The bit number comes from an 8-bit immediate field or from the full value of a register, picked by a select input.

Operands enter and results leave through valid/ready handshakes. The result is registered once, and a new operand may be accepted in the same cycle that the previous result is taken.

Top module: `bit_clear_unit`

## Requirements
- R1: Condition-code bit 2 (Z) of the result is 1 when the addressed bit of the operand was 0 before clearing, and 0 when it was 1.
- R2: In the result, the addressed bit is 0 and every other bit equals the operand.
- R3: When `dst_is_reg` is 1, the bit index is the low 5 bits of the selected bit number, so any of the 32 bits can be addressed.
- R4: When `dst_is_reg` is 0, the bit index is the low 3 bits of the selected bit number, and result bits 31:8 equal operand bits 31:8.
- R5: Index 0 addresses the least significant bit of the operand.
- R6: When `src_is_reg` is 1, the bit number is taken from `reg_bitnum`; when it is 0, it is taken from `imm_bitnum`.
- R7: Condition-code bits 4 (X), 3 (N), 1 (V) and 0 (C) of the output equal those of the input.
- R8: A result appears with `out_valid` high in the cycle after its operand is accepted. While `out_valid` is high and `out_ready` is low, it stays unchanged.
- R9: `in_ready` is high exactly when the output register is empty or is being drained in the same cycle. An accept and a drain in one cycle lose no result and repeat none.
- R10: Reset clears `out_valid`, `result` and `cc_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand bundle is present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| operand | input | 32 | Destination value before the operation |
| imm_bitnum | input | 8 | Bit number from the immediate field |
| reg_bitnum | input | 32 | Bit number held in a data register |
| src_is_reg | input | 1 | 1 selects `reg_bitnum`, 0 selects `imm_bitnum` |
| dst_is_reg | input | 1 | 1 for a 32-bit register destination, 0 for a memory byte |
| cc_in | input | 5 | Condition codes in: X,N,Z,V,C from bit 4 down to 0 |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| result | output | 32 | Operand with the addressed bit cleared |
| cc_out | output | 5 | Condition codes with Z updated |

## Verification
The two functions that can coincide are draining a held result and capturing a new operand, since both happen on one clock edge when `out_valid`, `out_ready` and `in_valid` are high together. The bench provokes this with random valid and ready patterns, including long runs with both held high. Every accepted operand goes into an ordered list of expected results, and every drained result must match the head of that list. A dropped, duplicated or reordered result therefore shows up as a mismatch.

// File: rtl/bit_clear_unit.sv
module bit_clear_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] operand,
  input  logic [7:0]  imm_bitnum,
  input  logic [31:0] reg_bitnum,
  input  logic        src_is_reg,
  input  logic        dst_is_reg,
  input  logic [4:0]  cc_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] result,
  output logic [4:0]  cc_out
);
  localparam int ZBIT = 2;

  logic [7:0]  bitnum;
  logic [4:0]  idx;
  logic        tested;
  logic [31:0] cleared;
  logic [4:0]  cc_next;
  logic        take;

  assign bitnum   = src_is_reg ? reg_bitnum[7:0] : imm_bitnum;
  assign idx      = dst_is_reg ? bitnum[4:0] : {2'b00, bitnum[2:0]};
  assign tested   = operand[idx];
  assign cleared  = operand & ~(32'd1 << idx);
  assign cc_next  = {cc_in[4:ZBIT+1], ~tested, cc_in[ZBIT-1:0]};
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc_out    <= '0;
    end else begin
      if (take) begin
        result <= cleared;
        cc_out <= cc_next;
      end
      if (take) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

module bit_clear_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] operand,
  input logic        dst_is_reg,
  input logic [4:0]  cc_in,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] result,
  input logic [4:0]  cc_out
);
  logic acc;
  assign acc = in_valid && in_ready;

  assert_z_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> cc_out[2] == (result == $past(operand)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ((result & ~$past(operand)) == 32'd0) && ($countones(result ^ $past(operand)) == 1 || result == $past(operand)));

  assert_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !dst_is_reg |=> result[31:8] == $past(operand[31:8]));

  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> cc_out[4:3] == $past(cc_in[4:3]) && cc_out[1:0] == $past(cc_in[1:0]));

  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(cc_out));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !acc |=> !out_valid);

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |-> !out_valid && result == 32'd0 && cc_out == 5'd0);
endmodule

bind bit_clear_unit bit_clear_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .operand(operand), .dst_is_reg(dst_is_reg), .cc_in(cc_in),
  .out_valid(out_valid), .out_ready(out_ready), .result(result), .cc_out(cc_out)
);

// File: tb/sim_bit_clear_unit.sv
`timescale 1ns/1ps
module sim_bit_clear_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] operand = '0;
  logic [7:0]  imm_bitnum = '0;
  logic [31:0] reg_bitnum = '0;
  logic        src_is_reg = 1'b0;
  logic        dst_is_reg = 1'b0;
  logic [4:0]  cc_in = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] result;
  logic [4:0]  cc_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] q_res[$];
  logic [4:0]  q_cc[$];
  logic        prev_hold = 1'b0;
  logic [31:0] prev_res = '0;
  logic [4:0]  prev_cc = '0;

  always #5 clk = ~clk;

  bit_clear_unit u0 (.*);

  function automatic logic [4:0] f_idx(logic [7:0] imm, logic [31:0] rg, logic sreg, logic dreg);
    logic [7:0] n;
    n = sreg ? rg[7:0] : imm;
    return dreg ? n[4:0] : {2'b00, n[2:0]};
  endfunction

  function automatic logic [31:0] f_res(logic [31:0] op, logic [4:0] i);
    logic [31:0] r;
    r = op;
    r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [4:0] f_cc(logic [31:0] op, logic [4:0] i, logic [4:0] c);
    logic [4:0] r;
    r = c;
    r[2] = ~op[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit ordy, input logic [31:0] op, input logic [7:0] imm,
                      input logic [31:0] rg, input bit sreg, input bit dreg, input logic [4:0] c);
    logic [4:0] i;
    @(negedge clk);
    if (prev_hold) begin
      check(out_valid === 1'b1, "R8 hold valid", {31'd0, out_valid}, 32'd1);
      check(result === prev_res && cc_out === prev_cc, "R8 hold stable", result, prev_res);
    end
    in_valid = iv; out_ready = ordy; operand = op; imm_bitnum = imm;
    reg_bitnum = rg; src_is_reg = sreg; dst_is_reg = dreg; cc_in = c;
    #1;
    check(in_ready === (!out_valid || out_ready), "R9 in_ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        check(1'b0, "R9 spurious result", result, 32'd0);
      end else begin
        logic [31:0] er;
        logic [4:0]  ec;
        er = q_res.pop_front();
        ec = q_cc.pop_front();
        check(result === er, "R2/R3/R4/R6 result", result, er);
        check(cc_out[2] === ec[2], "R1 zero flag", {27'd0, cc_out}, {27'd0, ec});
        check({cc_out[4:3], cc_out[1:0]} === {ec[4:3], ec[1:0]}, "R7 flags pass", {27'd0, cc_out}, {27'd0, ec});
      end
    end
    if (iv && in_ready) begin
      i = f_idx(imm, rg, sreg, dreg);
      q_res.push_back(f_res(op, i));
      q_cc.push_back(f_cc(op, i, c));
    end
    prev_hold = out_valid && !out_ready;
    prev_res = result;
    prev_cc = cc_out;
  endtask

  task automatic drain;
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && result === 32'd0 && cc_out === 5'd0, "R10 reset", result, 32'd0);
    rst_n = 1'b1;

    step(1'b1, 1'b1, 32'h0000_0001, 8'd0, 32'd0, 1'b0, 1'b1, 5'b11011);
    @(negedge clk); #1;
    check(out_valid === 1'b1, "R8 latency", {31'd0, out_valid}, 32'd1);
    check(result === 32'h0 && cc_out === 5'b11011, "R5 lsb index", result, 32'h0);
    step(1'b0, 1'b1, '0, '0, '0, 1'b0, 1'b0, '0);
    q_res.delete(); q_cc.delete();

    step(1'b1, 1'b1, 32'hFFFF_FFFF, 8'd0, 32'd37, 1'b1, 1'b1, 5'b00000);
    step(1'b1, 1'b1, 32'hFFFF_FFFF, 8'd31, 32'd0, 1'b0, 1'b1, 5'b11111);
    step(1'b1, 1'b1, 32'hFFFF_FFFF, 8'd13, 32'd0, 1'b0, 1'b0, 5'b10101);
    step(1'b1, 1'b1, 32'hABCD_EF00, 8'd2, 32'd255, 1'b1, 1'b0, 5'b01010);
    step(1'b1, 1'b1, 32'h0000_0080, 8'd7, 32'd3, 1'b0, 1'b1, 5'b00100);
    drain();
    step(1'b1, 1'b0, 32'h1234_5678, 8'd4, 32'd0, 1'b0, 1'b1, 5'b00000);
    step(1'b1, 1'b0, 32'h0, 8'd1, 32'd0, 1'b0, 1'b1, 5'b00000);
    step(1'b1, 1'b0, 32'h0, 8'd1, 32'd0, 1'b0, 1'b1, 5'b00000);
    drain();

    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) < 7, ($urandom % 10) < 6, $urandom, $urandom, $urandom,
           $urandom % 2, $urandom % 2, $urandom);
    end
    drain();
    check(q_res.size() == 0, "R9 nothing lost", q_res.size(), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule